// File: doc/BRIEF.md
# Stereo Serial Audio Receiver

This block takes in a three-wire serial audio stream: a bit clock, a channel-select line and a serial data line. Left and right samples share the data line and follow each other in turn. All three wires are asynchronous to the system clock. They pass through two-flop synchronisers, and the receiver acts on each rising edge of the bit clock that it detects. At every such edge it samples the channel-select and data levels.

Each 16-bit two's-complement word arrives most significant bit first. It goes to the left channel while channel-select is HIGH and to the right channel while it is LOW. A word is closed when channel-select changes level. The bit sampled on the edge that shows the new level already belongs to the next word. Once a left word and the right word after it are both held, the two output words are loaded in the same system clock cycle and a single-cycle valid strobe is raised. This happens at the LOW-to-HIGH change of channel-select.

Top module: `stereo_serial_rx`

## Requirements
- R1: A closed word equals the last 16 bits sampled before the channel-select change, with the first of those 16 bits placed at bit 15 (MSB first).
- R2: Bits sampled while channel-select is 1 form the word that appears on `left_word`. Bits sampled while it is 0 form the word that appears on `right_word`.
- R3: `left_word` and `right_word` take their new values in the same cycle. `pair_valid` is 1 in exactly that cycle and 0 in the cycle after it.
- R4: An output update needs a left word that closed before the right word. A right word with no left word held ahead of it (for example the first word after reset) produces no strobe and leaves the outputs unchanged.
- R5: Bits sampled early in a half-frame, beyond the last 16, are discarded and do not change the closed word.
- R6: When fewer than 16 bits arrive in a half-frame, the bits received fill the word from bit 15 downward and the remaining low-order bits are 0.
- R7: While `rst_n` is low, and right after it is released, `left_word` and `right_word` are 0 and `pair_valid` is 0.
- R8: Between strobes, `left_word` and `right_word` keep their values.
- R9: Data and channel-select are taken at the bit-clock rising edge. A change of data while the bit clock is high has no effect, provided the system clock runs at least 4 times the bit-clock rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_bclk | input | 1 | Serial bit clock, asynchronous |
| ser_chsel | input | 1 | Channel select, 1 = left, 0 = right, asynchronous |
| ser_data | input | 1 | Serial data, MSB first, asynchronous |
| left_word | output | 16 | Latest left sample |
| right_word | output | 16 | Latest right sample |
| pair_valid | output | 1 | One-cycle strobe when both outputs are updated |

## Verification
Frames with full 16-bit words use distinct left and right values: sign extremes, alternating patterns, all ones and all zeros. These catch swapped channels, reversed bit order and bit slips. A half-frame of 20 or 24 bits shows whether the early excess bits are dropped. Half-frames of 12 bits and of 1 bit show whether the zero fill is left-aligned. A lone right half-frame at the start separates a strobe that correctly waits for a left word from one that fires on any channel change. One frame flips the data line while the bit clock is high, which shows that sampling happens at the rising edge and not later.

// File: rtl/ssrx_pkg.sv
// Shared parameters and types for the stereo serial receiver.
// Assumes: one fixed sample width for both channels.
package ssrx_pkg;
    localparam int SAMPLE_W = 16;
    typedef logic [SAMPLE_W-1:0] sample_t;
endpackage

// File: rtl/ssrx_sync.sv
// Multi-bit synchroniser: each bit passes through STAGES flops.
// Assumes: the bits are independent levels; no bus coherence is needed.
module ssrx_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [STAGES-1:0][W-1:0] pipe;

    // Shift the asynchronous levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-2:0], async_in};
    end

    assign sync_out = pipe[STAGES-1];
endmodule

// File: rtl/ssrx_edge.sv
// Rising-edge detector on the synchronised bit clock.
// Assumes: the system clock runs at least 4x the bit clock.
module ssrx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic level_q;

    // Keep the previous level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    assign rise = level & ~level_q;

    // Two bit-clock edges are never in consecutive cycles at the supported ratio.
    assert_rise_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/ssrx_deser.sv
// Deserialiser: shifts bits MSB first and closes a word whenever the
// channel-select level changes between two bit-clock edges.
// Assumes: bit_rise is a single-cycle pulse per bit-clock rising edge.
module ssrx_deser
    import ssrx_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    bit_rise,
    input  logic    chsel_s,
    input  logic    data_s,
    output logic    done,
    output logic    done_left,
    output sample_t done_word
);
    localparam int CW = $clog2(SAMPLE_W + 1);

    sample_t         shreg;
    logic [CW-1:0]   fill;
    logic            prev_sel;
    logic            started;

    // Shift on each bit edge; on a channel change emit the left-aligned word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            fill      <= '0;
            prev_sel  <= 1'b0;
            started   <= 1'b0;
            done      <= 1'b0;
            done_left <= 1'b0;
            done_word <= '0;
        end else begin
            done <= 1'b0;
            if (bit_rise) begin
                if (started && (chsel_s != prev_sel)) begin
                    done      <= 1'b1;
                    done_left <= prev_sel;
                    done_word <= shreg << (CW'(SAMPLE_W) - fill);
                    shreg     <= {{(SAMPLE_W-1){1'b0}}, data_s};
                    fill      <= CW'(1);
                end else begin
                    shreg <= {shreg[SAMPLE_W-2:0], data_s};
                    if (fill != CW'(SAMPLE_W)) fill <= fill + CW'(1);
                end
                prev_sel <= chsel_s;
                started  <= 1'b1;
            end
        end
    end

    // The fill count never exceeds the word width.
    assert_fill_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(SAMPLE_W));
    // A closed word is reported only one cycle after a bit edge.
    assert_done_after_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bit_rise));
endmodule

// File: rtl/ssrx_pair.sv
// Pair assembler: holds the left word and loads both outputs together
// once the following right word closes.
// Assumes: done pulses alternate between the channels.
module ssrx_pair
    import ssrx_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    done,
    input  logic    done_left,
    input  sample_t done_word,
    output sample_t out_left,
    output sample_t out_right,
    output logic    out_valid
);
    sample_t left_hold;
    logic    left_ok;

    // Park left words; publish the pair when a right word follows one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_hold <= '0;
            left_ok   <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (done) begin
                if (done_left) begin
                    left_hold <= done_word;
                    left_ok   <= 1'b1;
                end else if (left_ok) begin
                    out_left  <= left_hold;
                    out_right <= done_word;
                    out_valid <= 1'b1;
                    left_ok   <= 1'b0;
                end
            end
        end
    end

    // The strobe lasts exactly one cycle.
    assert_strobe_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    // Outputs move only together with the strobe.
    assert_hold_between_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_left) && $stable(out_right)));
    // A strobe needs a right word closing in the previous cycle.
    assert_pair_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(done) && !$past(done_left)));
endmodule

// File: rtl/stereo_serial_rx.sv
// Top level: synchronisers, bit-edge detector, deserialiser, pair assembler.
// Assumes: the system clock is at least 4x the bit clock; inputs meet the
// serial setup and hold limits around the bit-clock rising edge.
module stereo_serial_rx
    import ssrx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_bclk,
    input  logic                ser_chsel,
    input  logic                ser_data,
    output logic [SAMPLE_W-1:0] left_word,
    output logic [SAMPLE_W-1:0] right_word,
    output logic                pair_valid
);
    logic [2:0] sync_v;
    logic       bit_rise;
    logic       done;
    logic       done_left;
    sample_t    done_word;

    ssrx_sync #(.W(3), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_bclk, ser_chsel, ser_data}),
        .sync_out (sync_v)
    );

    ssrx_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (sync_v[2]),
        .rise  (bit_rise)
    );

    ssrx_deser u_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_rise  (bit_rise),
        .chsel_s   (sync_v[1]),
        .data_s    (sync_v[0]),
        .done      (done),
        .done_left (done_left),
        .done_word (done_word)
    );

    ssrx_pair u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (done),
        .done_left (done_left),
        .done_word (done_word),
        .out_left  (left_word),
        .out_right (right_word),
        .out_valid (pair_valid)
    );
endmodule

// File: tb/stereo_serial_rx_tb_top.sv
// Scoreboard bench: the driver queues expected pairs, the monitor checks strobes.
module stereo_serial_rx_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_bclk = 1'b0;
    logic        ser_chsel = 1'b0;
    logic        ser_data = 1'b0;
    logic [15:0] left_word;
    logic [15:0] right_word;
    logic        pair_valid;

    int n_checks = 0;
    int n_fail   = 0;
    int n_strobe = 0;
    int n_expect = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          done_flag = 0;

    always #2.5 clk = ~clk;

    stereo_serial_rx dut_i (
        .clk(clk), .rst_n(rst_n), .ser_bclk(ser_bclk), .ser_chsel(ser_chsel),
        .ser_data(ser_data), .left_word(left_word), .right_word(right_word),
        .pair_valid(pair_valid)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // One bit: set levels while the bit clock is low, then a high phase.
    task automatic send_bit(input logic sel, input logic d, input bit glitch);
        @(negedge clk);
        ser_chsel = sel;
        ser_data  = d;
        repeat (4) @(negedge clk);
        ser_bclk = 1'b1;
        if (glitch) begin
            repeat (3) @(negedge clk);
            ser_data = ~d;
            @(negedge clk);
        end else begin
            repeat (4) @(negedge clk);
        end
        ser_bclk = 1'b0;
    endtask

    // A half-frame: junk bits first, then nbits of w from bit 15 down.
    task automatic send_half(input logic sel, input logic [15:0] w, input int nbits,
                             input int extra, input bit glitch);
        for (int i = 0; i < extra; i++) send_bit(sel, i[0], 1'b0);
        for (int i = 0; i < nbits; i++) send_bit(sel, w[15-i], glitch);
    endtask

    function automatic logic [15:0] top_bits(input logic [15:0] w, input int n);
        logic [15:0] m;
        m = (n >= 16) ? 16'hFFFF : ~(16'hFFFF >> n);
        return w & m;
    endfunction

    // Full frame: left then right; the pair appears at the next left half.
    task automatic frame(input logic [15:0] l, input int ln, input int lx,
                         input logic [15:0] r, input int rn, input int rx,
                         input bit glitch, input string tag);
        send_half(1'b1, l, ln, lx, glitch);
        exp_q.push_back({top_bits(l, ln), top_bits(r, rn)});
        tag_q.push_back(tag);
        n_expect++;
        send_half(1'b0, r, rn, rx, glitch);
    endtask

    // Monitor: compare each strobe with the queue, watch hold and pulse width.
    logic [15:0] last_l = '0;
    logic [15:0] last_r = '0;
    bit          moved = 0;
    bit          pulse_pend = 0;
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            if (pulse_pend) begin
                check(!pair_valid, "R3 strobe width", {31'd0, pair_valid}, 32'd0);
                pulse_pend = 0;
            end
            if (pair_valid) begin
                logic [31:0] e;
                string t;
                n_strobe++;
                pulse_pend = 1;
                check(!moved, "R8 hold between strobes", {31'd0, moved}, 32'd0);
                moved = 0;
                if (exp_q.size() == 0) begin
                    check(0, "R4 unexpected strobe", {left_word, right_word}, 32'd0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(left_word == e[31:16], {"R2 R3 left ", t},
                          {16'd0, left_word}, {16'd0, e[31:16]});
                    check(right_word == e[15:0], {"R2 R3 right ", t},
                          {16'd0, right_word}, {16'd0, e[15:0]});
                end
                last_l = left_word;
                last_r = right_word;
            end else if (left_word != last_l || right_word != last_r) begin
                moved = 1;
            end
        end
    end

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R7: reset state while held in reset.
        check(left_word == 16'h0, "R7 left in reset", {16'd0, left_word}, 32'd0);
        check(right_word == 16'h0, "R7 right in reset", {16'd0, right_word}, 32'd0);
        check(!pair_valid, "R7 strobe in reset", {31'd0, pair_valid}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(left_word == 16'h0 && right_word == 16'h0 && !pair_valid,
              "R7 after release", {left_word, right_word}, 32'd0);

        // R4: a lone right half-frame first must not produce a pair.
        send_half(1'b0, 16'hDEAD, 16, 0, 1'b0);
        // R1 R2: full words with distinct patterns.
        frame(16'h8000, 16, 0, 16'h7FFF, 16, 0, 1'b0, "R1 sign extremes");
        frame(16'hFFFF, 16, 0, 16'h0001, 16, 0, 1'b0, "R1 ones vs one");
        frame(16'hA5A5, 16, 0, 16'h5A5A, 16, 0, 1'b0, "R1 alternating");
        frame(16'h0000, 16, 0, 16'hFFFF, 16, 0, 1'b0, "R1 zeros vs ones");
        // R5: excess early bits are dropped.
        frame(16'h1234, 16, 4, 16'hCAFE, 16, 8, 1'b0, "R5 extra bits");
        // R6: short half-frames are zero-filled at the bottom.
        frame(16'hABCD, 12, 0, 16'h8000, 1, 0, 1'b0, "R6 short words");
        // R9: data flipped while the bit clock is high is ignored.
        frame(16'h3C96, 16, 0, 16'hE1F0, 16, 0, 1'b1, "R9 late data change");
        // Flush: one left bit closes the last right word.
        send_bit(1'b1, 1'b0, 1'b0);
        repeat (40) @(negedge clk);
        done_flag = 1;
        check(n_strobe == n_expect, "R4 strobe count", n_strobe, n_expect);
        check(exp_q.size() == 0, "R4 pending pairs", exp_q.size(), 32'd0);
        summary();
    end
endmodule